// File: doc/BRIEF.md
# Write-Order Shadow Matrix

This block forces a group of N function units to finish their work in the order in which they were issued. It keeps an N-by-N bit matrix in which row i records which units were already in flight when unit i was issued. Each set bit is a shadow: an older unit that still has to finish before unit i may write its result. Because every in-flight unit shadows every unit issued after it, the matrix works as a linked list of program order. Every completion is strictly ordered, so stores leave the unit group in issue order. This gives write-after-write protection, including between two stores.

The issue logic raises a per-unit issue strobe when it hands an operation to a unit. A unit raises its done strobe when it wants to write its result. The block grants one per-unit commit flag. At any time that flag is high for at most one unit: the oldest unit still in flight. A done strobe is accepted only from the unit whose commit flag is high. Any other done strobe is ignored, and that unit must present it again later.

Top module: `wo_shadow_matrix`

## Requirements
- R1: After reset, no unit is in flight and every bit of commit_ok_o is 0.
- R2: An issue strobe to an idle unit while no unit is in flight, and with no lower-numbered unit issuing in the same cycle, sets that unit's commit_ok_o bit in the cycle after the issuing clock edge.
- R3: A unit issued while other units are in flight keeps commit_ok_o low until every one of those units has completed.
- R4: A done strobe is accepted only from the unit whose commit_ok_o bit is high. A done strobe from a unit that is held or idle is ignored, and that unit stays in flight in the same order position.
- R5: An issue strobe to a unit that is already in flight is ignored. The unit's order position does not change.
- R6: When several units issue in the same cycle, a lower unit index counts as older than a higher one.
- R7: At most one bit of commit_ok_o is high in any cycle.
- R8: A unit that completes in the same cycle as another unit issues casts no shadow on the newly issued unit.
- R9: When the unit holding commit_ok_o completes, the next-oldest in-flight unit gets commit_ok_o in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | N | Per-unit issue strobe, one cycle per issue |
| done_i | input | N | Per-unit completion request strobe |
| commit_ok_o | output | N | Per-unit commit-permitted flag, from registered state |

## Verification
A four-unit configuration is driven through all 24 orders in which the units can be issued one per cycle. Each order is then drained with random, out-of-order done patterns. This separates an order kept in the matrix from one that only follows index or completion order. A long random phase mixes simultaneous issues, issues to busy units, and completions in the same cycle as issues. This exercises the same-cycle tie rule and the rule that a retiring unit casts no shadow. Directed cases cover done strobes from held units and repeat issues to busy units, which must leave the order unchanged.

// File: rtl/wo_shadow_pkg.sv
package wo_shadow_pkg;

    typedef enum logic [1:0] {
        SLOT_IDLE  = 2'd0,
        SLOT_HELD  = 2'd1,
        SLOT_CLEAR = 2'd2
    } slot_state_e;

endpackage

// File: rtl/wo_strobe_qual.sv
module wo_strobe_qual
    import wo_shadow_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0]      issue_i,
    input  logic [N-1:0]      done_i,
    input  logic [N-1:0]      busy_i,
    input  slot_state_e       state_i [N],
    output logic [N-1:0]      issue_acc_o,
    output logic [N-1:0]      retire_acc_o
);

    logic [N-1:0] clear_vec;

    for (genvar g = 0; g < N; g++) begin : g_clear
        assign clear_vec[g] = (state_i[g] == SLOT_CLEAR);
    end

    always_comb begin
        issue_acc_o  = issue_i & ~busy_i;
        retire_acc_o = done_i & clear_vec;
    end

endmodule

// File: rtl/wo_shadow_row.sv
module wo_shadow_row
    import wo_shadow_pkg::*;
#(
    parameter int N   = 8,
    parameter int IDX = 0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N-1:0]      issue_acc_i,
    input  logic [N-1:0]      retire_acc_i,
    input  logic [N-1:0]      busy_all_i,
    output logic              busy_o,
    output slot_state_e       state_o
);

    localparam logic [N-1:0] OLDER_MASK = N'((64'd1 << IDX) - 64'd1);

    typedef struct packed {
        logic         busy;
        logic [N-1:0] shadow;
    } row_t;

    row_t row_d, row_q;

    always_comb begin
        row_d = row_q;
        if (retire_acc_i[IDX]) begin
            row_d.busy   = 1'b0;
            row_d.shadow = '0;
        end else if (issue_acc_i[IDX]) begin
            row_d.busy   = 1'b1;
            row_d.shadow = (busy_all_i & ~retire_acc_i) | (issue_acc_i & OLDER_MASK);
        end else begin
            row_d.shadow = row_q.shadow & ~retire_acc_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) row_q <= '0;
        else         row_q <= row_d;
    end

    assign busy_o  = row_q.busy;
    assign state_o = !row_q.busy          ? SLOT_IDLE :
                     (row_q.shadow == '0) ? SLOT_CLEAR : SLOT_HELD;

    a_r2_lone_issue_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (issue_acc_i[IDX] && busy_all_i == '0 && (issue_acc_i & OLDER_MASK) == '0)
        |=> state_o == SLOT_CLEAR);

    a_r4_retire_only_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        retire_acc_i[IDX] |-> (row_q.busy && row_q.shadow == '0));

    a_r5_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (row_q.busy && !retire_acc_i[IDX]) |=> row_q.busy);

    a_r3_shadow_never_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (row_q.busy && !retire_acc_i[IDX]) |=> (row_q.shadow & ~$past(row_q.shadow)) == '0);

    a_r8_shadow_on_live_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        row_q.busy |-> (row_q.shadow & ~busy_all_i) == '0);

endmodule

// File: rtl/wo_shadow_matrix.sv
module wo_shadow_matrix
    import wo_shadow_pkg::*;
#(
    parameter int N = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [N-1:0]  issue_i,
    input  logic [N-1:0]  done_i,
    output logic [N-1:0]  commit_ok_o
);

    logic [N-1:0] busy_vec;
    logic [N-1:0] issue_acc;
    logic [N-1:0] retire_acc;
    slot_state_e  state_vec [N];

    wo_strobe_qual #(.N(N)) qual_i (
        .issue_i      (issue_i),
        .done_i       (done_i),
        .busy_i       (busy_vec),
        .state_i      (state_vec),
        .issue_acc_o  (issue_acc),
        .retire_acc_o (retire_acc)
    );

    for (genvar g = 0; g < N; g++) begin : g_row
        wo_shadow_row #(.N(N), .IDX(g)) row_i (
            .clk_i        (clk_i),
            .rst_ni       (rst_ni),
            .issue_acc_i  (issue_acc),
            .retire_acc_i (retire_acc),
            .busy_all_i   (busy_vec),
            .busy_o       (busy_vec[g]),
            .state_o      (state_vec[g])
        );
        assign commit_ok_o[g] = (state_vec[g] == SLOT_CLEAR);
    end

    a_r7_single_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(commit_ok_o));

    a_r9_retire_clears_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (retire_acc != '0) |=> (commit_ok_o & $past(retire_acc)) == '0);

endmodule

// File: tb/wo_shadow_matrix_tb.sv
`timescale 1ns/1ps
module wo_shadow_matrix_tb_top;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] issue = '0;
    logic [N-1:0] done = '0;
    logic [N-1:0] commit_ok;

    int vectors = 0;
    int errors  = 0;
    int order_q[$];
    logic [N-1:0] busy_m = '0;

    always #2.5 clk = ~clk;

    wo_shadow_matrix #(.N(N)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .issue_i     (issue),
        .done_i      (done),
        .commit_ok_o (commit_ok)
    );

    function automatic logic [N-1:0] expect_vec();
        if (order_q.size() == 0) return '0;
        return N'(1) << order_q[0];
    endfunction

    task automatic check(input string tag, input logic [N-1:0] exp);
        vectors++;
        if (commit_ok !== exp) begin
            errors++;
            $display("FAIL %s: commit_ok=%b expected=%b", tag, commit_ok, exp);
        end
    endtask

    task automatic step(input logic [N-1:0] iss, input logic [N-1:0] dn, input string tag);
        logic [N-1:0] busy_pre;
        @(negedge clk);
        issue = iss;
        done  = dn;
        busy_pre = busy_m;
        if (order_q.size() != 0 && dn[order_q[0]]) begin
            busy_m[order_q[0]] = 1'b0;
            void'(order_q.pop_front());
        end
        for (int k = 0; k < N; k++) begin
            if (iss[k] && !busy_pre[k]) begin
                order_q.push_back(k);
                busy_m[k] = 1'b1;
            end
        end
        @(posedge clk);
        #1;
        issue = '0;
        done  = '0;
        check(tag, expect_vec());
        if (!$onehot0(commit_ok)) begin
            errors++;
            $display("FAIL R7: commit_ok=%b expected at most one bit", commit_ok);
        end
    endtask

    task automatic drain(input string tag);
        for (int c = 0; c < 60 && order_q.size() != 0; c++)
            step('0, N'($urandom), tag);
        while (order_q.size() != 0) step('0, '1, tag);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: run did not end, actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", '0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 after release", '0);

        step(4'b0100, '0, "R2 lone issue");
        step('0, 4'b0100, "R9 retire lone");
        step(4'b1010, '0, "R6 simultaneous issue, lower index older");
        step('0, 4'b1000, "R4 done from held unit ignored");
        step(4'b0010, '0, "R5 reissue of busy unit ignored");
        step('0, 4'b0010, "R9 next oldest takes flag");
        step(4'b0001, 4'b1000, "R8 retire and issue same cycle");
        step(4'b0100, '0, "R3 issue behind live unit");
        step('0, 4'b0100, "R4 held unit done ignored");
        step('0, 4'b0001, "R9 hand over");
        step('0, 4'b0100, "R9 drain");

        for (int a = 0; a < N; a++)
            for (int b = 0; b < N; b++)
                for (int c = 0; c < N; c++)
                    for (int d = 0; d < N; d++) begin
                        if (a == b || a == c || a == d || b == c || b == d || c == d) continue;
                        step(N'(1) << a, '0, "R2 permutation first issue");
                        step(N'(1) << b, '0, "R3 permutation issue");
                        step(N'(1) << c, '0, "R3 permutation issue");
                        step(N'(1) << d, '0, "R3 permutation issue");
                        drain("R3 out-of-order done");
                    end

        for (int i = 0; i < 3000; i++)
            step(N'($urandom), N'($urandom), "R6 R8 random mix");
        drain("R9 final drain");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule